// File: doc/BRIEF.md
# Host-Programmed AUX Request Engine

This block is a byte-wide register bank through which a host assembles one DisplayPort-style AUX request and sends it to a link-side agent. The host programs a 20-bit target address, a 4-bit request code and a transfer length. For write requests it also queues payload bytes one at a time. It then sets a send bit. The engine offers the request on a valid/ready port. It waits for a reply on a second valid/ready port and retries on its own whenever the reply is a defer. When the final outcome arrives it drops the send bit and posts a status byte.

The host polls the send bit until it reads 0. It then reads the status byte, which holds a 3-bit reply code and a 5-bit byte count. Bytes returned by a read request are taken one per access from a receive port register. Writing 0xFF to the channel-reset register clears both byte buffers and the status.

Top module: `aux_xact_engine`

## Requirements
- R1: After reset every readable register (0x7D, 0x7E, 0x7F, 0x80, 0x83, 0x84) reads 0x00, and reading 0x82 returns 0x00.
- R2: The request is built from the register fields. `lreq_addr[7:0]` comes from 0x7D, `[15:8]` from 0x7E and `[19:16]` from 0x7F bits 3:0. `lreq_cmd` comes from 0x7F bits 7:4. `lreq_len` is register 0x80 bits 3:0 plus one, or 0 when bit 7 of 0x80 is set.
- R3: Each write to 0x81 queues one byte. The k-th queued byte appears on `lreq_data[8k+7:8k]`. Bytes beyond 16 are dropped.
- R4: Writing 0x83 with bit 0 set launches a request with a valid code. Bit 0 of 0x83 reads 1 until the final reply is taken or the transaction fails, and reads 0 afterwards.
- R5: `lreq_valid` stays high with stable request fields until `lreq_ready` is seen. `rsp_ready` is high only after the request has been accepted, and a reply counts only when `rsp_valid` and `rsp_ready` are both high.
- R6: A final reply sets 0x84 to {reply code in bits 7:5, `rsp_count` in bits 4:0}. Reply codes are 1 native NACK, 3 ACK and 5 I2C NACK.
- R7: For a read code (bit 0 of the code set), the bytes from the reply are stored with byte k taken from `rsp_data[8k+7:8k]`. Each read of 0x82 returns the next byte in order. Once the stored bytes run out, 0x82 returns 0x00 and does not wrap.
- R8: A reply with code 2 or 6 (defer) re-issues the same request. After MAX_RETRY re-issues, a further defer ends the transaction with status 0xE0.
- R9: If no reply is accepted within WAIT_LIMIT cycles of the request handshake, the transaction ends with status 0xE0 (code 7, count 0).
- R10: Only codes 0x0, 0x1, 0x4, 0x5, 0x8 and 0x9 are valid (bit 2 is the I2C continuation flag). Any other code sets status 0x80 at once, leaves the send bit at 0 and raises no request.
- R11: While a transaction is in flight, every host write is ignored. This covers send, the field registers, the payload port and the channel reset.
- R12: Writing 0xFF to 0x76 while idle clears the status and both buffers. Any other value written to 0x76 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe (pops 0x82) |
| host_addr | input | 8 | Register offset |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data for `host_addr`, combinational |
| lreq_valid | output | 1 | Request offered to the link |
| lreq_ready | input | 1 | Link accepts the request |
| lreq_cmd | output | 4 | Request code |
| lreq_addr | output | 20 | Target address |
| lreq_len | output | 5 | Payload length, 0 to 16 |
| lreq_data | output | 128 | Write payload, byte k at bits 8k+7:8k |
| rsp_valid | input | 1 | Reply present |
| rsp_ready | output | 1 | Engine waiting for a reply |
| rsp_code | input | 3 | Reply code |
| rsp_count | input | 5 | Bytes handled by the link |
| rsp_data | input | 128 | Returned read bytes |

## Verification
The main path is exercised with a native write that carries three payload bytes and a ready that arrives late. It is also run with an I2C read that sets the continuation flag and returns four bytes, and with a native NACK. Together these separate field packing, payload ordering, the read/write split and status formation. Separate runs cover a defer sequence that ends in an ACK, a defer sequence that exhausts the retry limit and a link that never replies. These tell retry handling apart from the timeout path. Further runs cover an invalid code, host writes issued mid-flight, a 17-byte payload overflow, the no-payload flag and the channel reset with a non-0xFF value. A reference model in the bench compares the offered request against the programmed fields on every clock.

// File: rtl/aux_eng_pkg.sv
package aux_eng_pkg;
  typedef enum logic [2:0] {
    RC_NONE      = 3'd0,
    RC_NACK      = 3'd1,
    RC_DEFER     = 3'd2,
    RC_ACK       = 3'd3,
    RC_BADREQ    = 3'd4,
    RC_I2C_NACK  = 3'd5,
    RC_I2C_DEFER = 3'd6,
    RC_TIMEOUT   = 3'd7
  } reply_e;

  localparam logic [7:0] OFS_CHRST = 8'h76;
  localparam logic [7:0] OFS_ALO   = 8'h7D;
  localparam logic [7:0] OFS_AMID  = 8'h7E;
  localparam logic [7:0] OFS_AHI   = 8'h7F;
  localparam logic [7:0] OFS_LEN   = 8'h80;
  localparam logic [7:0] OFS_TXD   = 8'h81;
  localparam logic [7:0] OFS_RXD   = 8'h82;
  localparam logic [7:0] OFS_CTL   = 8'h83;
  localparam logic [7:0] OFS_STS   = 8'h84;

  function automatic logic code_ok(input logic [3:0] c);
    return (c == 4'h0) || (c == 4'h1) || (c == 4'h4) || (c == 4'h5) ||
           (c == 4'h8) || (c == 4'h9);
  endfunction
endpackage

// File: rtl/aux_tx_buf.sv
module aux_tx_buf #(
  parameter int DEPTH = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               push,
  input  logic [7:0]         din,
  output logic [DEPTH*8-1:0] flat
);
  localparam int CW = $clog2(DEPTH + 1);
  logic [CW-1:0] cnt;

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flat[g*8 +: 8] <= '0;
      else if (push && !clr && cnt == CW'(g)) flat[g*8 +: 8] <= din;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (clr) cnt <= '0;
    else if (push && cnt != CW'(DEPTH)) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/aux_rx_buf.sv
module aux_rx_buf #(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               load,
  input  logic [DEPTH*8-1:0] load_vec,
  input  logic [CW-1:0]      load_cnt,
  input  logic               pop,
  output logic [7:0]         head
);
  logic [7:0]    mem [DEPTH];
  logic [CW-1:0] cnt, rp;

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mem[g] <= '0;
      else if (load) mem[g] <= load_vec[g*8 +: 8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      rp  <= '0;
    end else if (clr) begin
      cnt <= '0;
      rp  <= '0;
    end else if (load) begin
      cnt <= load_cnt;
      rp  <= '0;
    end else if (pop && rp < cnt) begin
      rp <= rp + 1'b1;
    end
  end

  always_comb begin
    head = 8'h00;
    for (int i = 0; i < DEPTH; i++)
      if (rp < cnt && rp == CW'(i)) head = mem[i];
  end
endmodule

// File: rtl/aux_xact_seq.sv
module aux_xact_seq
  import aux_eng_pkg::*;
#(
  parameter int WAIT_LIMIT = 64,
  parameter int MAX_RETRY  = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       cmd_ok,
  input  logic       lreq_ready,
  input  logic       rsp_valid,
  input  logic [2:0] rsp_code,
  output logic       lreq_valid,
  output logic       rsp_ready,
  output logic       busy,
  output logic       done,
  output logic [2:0] done_code,
  output logic       take_rsp
);
  localparam int TW = $clog2(WAIT_LIMIT + 1);
  localparam int RW = $clog2(MAX_RETRY + 2);

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT} state_e;
  state_e        st, st_nx;
  logic [TW-1:0] timer;
  logic [RW-1:0] tries;
  logic          is_defer, retry;

  assign lreq_valid = (st == S_REQ);
  assign rsp_ready  = (st == S_WAIT);
  assign busy       = (st != S_IDLE);
  assign is_defer   = (rsp_code == RC_DEFER) || (rsp_code == RC_I2C_DEFER);

  always_comb begin
    st_nx     = st;
    done      = 1'b0;
    done_code = RC_NONE;
    take_rsp  = 1'b0;
    retry     = 1'b0;
    case (st)
      S_IDLE: if (start) begin
        if (cmd_ok) st_nx = S_REQ;
        else begin
          done      = 1'b1;
          done_code = RC_BADREQ;
        end
      end
      S_REQ: if (lreq_ready) st_nx = S_WAIT;
      S_WAIT: begin
        if (rsp_valid) begin
          if (is_defer) begin
            if (tries == RW'(MAX_RETRY)) begin
              done      = 1'b1;
              done_code = RC_TIMEOUT;
              st_nx     = S_IDLE;
            end else begin
              retry = 1'b1;
              st_nx = S_REQ;
            end
          end else begin
            done      = 1'b1;
            done_code = rsp_code;
            take_rsp  = 1'b1;
            st_nx     = S_IDLE;
          end
        end else if (timer == TW'(WAIT_LIMIT - 1)) begin
          done      = 1'b1;
          done_code = RC_TIMEOUT;
          st_nx     = S_IDLE;
        end
      end
      default: st_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      timer <= '0;
      tries <= '0;
    end else begin
      st <= st_nx;
      if (st == S_REQ) timer <= '0;
      else if (st == S_WAIT) timer <= timer + 1'b1;
      if (st == S_IDLE) tries <= '0;
      else if (retry) tries <= tries + 1'b1;
    end
  end
endmodule

// File: rtl/aux_xact_engine.sv
module aux_xact_engine
  import aux_eng_pkg::*;
#(
  parameter int DEPTH      = 16,
  parameter int WAIT_LIMIT = 64,
  parameter int MAX_RETRY  = 3,
  localparam int LW = $clog2(DEPTH + 1),
  localparam int DW = DEPTH * 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_wr,
  input  logic          host_rd,
  input  logic [7:0]    host_addr,
  input  logic [7:0]    host_wdata,
  output logic [7:0]    host_rdata,
  output logic          lreq_valid,
  input  logic          lreq_ready,
  output logic [3:0]    lreq_cmd,
  output logic [19:0]   lreq_addr,
  output logic [LW-1:0] lreq_len,
  output logic [DW-1:0] lreq_data,
  input  logic          rsp_valid,
  output logic          rsp_ready,
  input  logic [2:0]    rsp_code,
  input  logic [4:0]    rsp_count,
  input  logic [DW-1:0] rsp_data
);
  logic [7:0]    a_lo, a_mid, a_hi, len_r, status;
  logic          busy, wr_ok, start, chan_clr, cmd_ok;
  logic          done, take_rsp;
  logic [2:0]    done_code;
  logic [7:0]    rx_head;
  logic [LW-1:0] rx_cnt;

  assign wr_ok    = host_wr && !busy;
  assign start    = wr_ok && host_addr == OFS_CTL && host_wdata[0];
  assign chan_clr = wr_ok && host_addr == OFS_CHRST && host_wdata == 8'hFF;
  assign cmd_ok   = code_ok(a_hi[7:4]);

  assign lreq_cmd  = a_hi[7:4];
  assign lreq_addr = {a_hi[3:0], a_mid, a_lo};
  assign lreq_len  = len_r[7] ? '0 : LW'(len_r[3:0]) + 1'b1;
  assign rx_cnt    = (rsp_count > 5'(DEPTH)) ? LW'(DEPTH) : LW'(rsp_count);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_lo   <= '0;
      a_mid  <= '0;
      a_hi   <= '0;
      len_r  <= '0;
      status <= '0;
    end else begin
      if (wr_ok) begin
        case (host_addr)
          OFS_ALO:  a_lo  <= host_wdata;
          OFS_AMID: a_mid <= host_wdata;
          OFS_AHI:  a_hi  <= host_wdata;
          OFS_LEN:  len_r <= host_wdata;
          default: ;
        endcase
      end
      if (done) status <= {done_code, take_rsp ? rsp_count : 5'd0};
      else if (start || chan_clr) status <= '0;
    end
  end

  aux_xact_seq #(.WAIT_LIMIT(WAIT_LIMIT), .MAX_RETRY(MAX_RETRY)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd_ok(cmd_ok),
    .lreq_ready(lreq_ready), .rsp_valid(rsp_valid), .rsp_code(rsp_code),
    .lreq_valid(lreq_valid), .rsp_ready(rsp_ready), .busy(busy),
    .done(done), .done_code(done_code), .take_rsp(take_rsp)
  );

  aux_tx_buf #(.DEPTH(DEPTH)) u_tx (
    .clk(clk), .rst_n(rst_n), .clr(chan_clr || done),
    .push(wr_ok && host_addr == OFS_TXD), .din(host_wdata), .flat(lreq_data)
  );

  aux_rx_buf #(.DEPTH(DEPTH)) u_rx (
    .clk(clk), .rst_n(rst_n), .clr(chan_clr || start),
    .load(take_rsp && lreq_cmd[0]), .load_vec(rsp_data), .load_cnt(rx_cnt),
    .pop(host_rd && host_addr == OFS_RXD), .head(rx_head)
  );

  always_comb begin
    case (host_addr)
      OFS_ALO:  host_rdata = a_lo;
      OFS_AMID: host_rdata = a_mid;
      OFS_AHI:  host_rdata = a_hi;
      OFS_LEN:  host_rdata = len_r;
      OFS_RXD:  host_rdata = rx_head;
      OFS_CTL:  host_rdata = {7'd0, busy};
      OFS_STS:  host_rdata = status;
      default:  host_rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/aux_xact_engine_chk.sv
module aux_xact_engine_chk #(
  parameter int DEPTH = 16,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             host_wr,
  input logic [7:0]       host_addr,
  input logic [7:0]       host_wdata,
  input logic             lreq_valid,
  input logic             lreq_ready,
  input logic [3:0]       lreq_cmd,
  input logic [19:0]      lreq_addr,
  input logic [LW-1:0]    lreq_len,
  input logic [DEPTH*8-1:0] lreq_data,
  input logic             rsp_ready,
  input logic             busy,
  input logic             cmd_ok
);
  p_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (lreq_valid && !lreq_ready) |=> (lreq_valid && $stable(lreq_cmd) &&
      $stable(lreq_addr) && $stable(lreq_len) && $stable(lreq_data)));

  p_rsp_after_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(lreq_valid && rsp_ready));

  p_launch_offers_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> lreq_valid);

  p_busy_has_phase_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (lreq_valid || rsp_ready));

  p_end_from_wait_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(rsp_ready));

  p_bad_code_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_addr == 8'h83 && host_wdata[0] && !busy && !cmd_ok) |=> !busy);
endmodule

bind aux_xact_engine aux_xact_engine_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
  .host_wdata(host_wdata), .lreq_valid(lreq_valid), .lreq_ready(lreq_ready),
  .lreq_cmd(lreq_cmd), .lreq_addr(lreq_addr), .lreq_len(lreq_len),
  .lreq_data(lreq_data), .rsp_ready(rsp_ready), .busy(busy), .cmd_ok(cmd_ok)
);

// File: tb/test_aux_xact_engine.sv
module test_aux_xact_engine;
  localparam int DEPTH = 16;
  localparam int WLIM  = 64;

  logic         clk = 1'b0, rst_n = 1'b0;
  logic         host_wr = 0, host_rd = 0;
  logic [7:0]   host_addr = 0, host_wdata = 0, host_rdata;
  logic         lreq_valid, lreq_ready = 0, rsp_valid = 0, rsp_ready;
  logic [3:0]   lreq_cmd;
  logic [19:0]  lreq_addr;
  logic [4:0]   lreq_len;
  logic [127:0] lreq_data, rsp_data = '0;
  logic [2:0]   rsp_code = 0;
  logic [4:0]   rsp_count = 0;

  int checks = 0, fails = 0, req_hs = 0, valid_cycles = 0;
  bit finished = 0;

  // reference model of the expected request
  logic [3:0]  exp_cmd;
  logic [19:0] exp_addr;
  logic [4:0]  exp_len;
  logic [7:0]  exp_b[$];

  always #5 clk = ~clk;

  aux_xact_engine #(.DEPTH(DEPTH), .WAIT_LIMIT(WLIM), .MAX_RETRY(3)) i_aux_xact_engine (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .lreq_valid(lreq_valid), .lreq_ready(lreq_ready), .lreq_cmd(lreq_cmd),
    .lreq_addr(lreq_addr), .lreq_len(lreq_len), .lreq_data(lreq_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_code(rsp_code),
    .rsp_count(rsp_count), .rsp_data(rsp_data)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // per-clock comparison of the offered request against the model (R2, R3, R5)
  always @(negedge clk) begin
    if (rst_n && lreq_valid) begin
      valid_cycles++;
      check("R2 req fields", {lreq_cmd, lreq_addr, 3'b0, lreq_len},
            {exp_cmd, exp_addr, 3'b0, exp_len});
      foreach (exp_b[i])
        if (i < DEPTH) check("R3 payload byte", {24'd0, lreq_data[i*8 +: 8]}, {24'd0, exp_b[i]});
    end
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    host_wr = 1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    host_rd = 1; host_addr = a;
    #1 d = host_rdata;
    @(negedge clk);
    host_rd = 0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [7:0] e);
    logic [7:0] d;
    rd(a, d);
    check(req, {24'd0, d}, {24'd0, e});
  endtask

  task automatic prog(input logic [3:0] c, input logic [19:0] ad, input logic [7:0] lf);
    wr(8'h7D, ad[7:0]);
    wr(8'h7E, ad[15:8]);
    wr(8'h7F, {c, ad[19:16]});
    wr(8'h80, lf);
    exp_cmd  = c;
    exp_addr = ad;
    exp_len  = lf[7] ? 5'd0 : {1'b0, lf[3:0]} + 5'd1;
    exp_b.delete();
  endtask

  task automatic push(input logic [7:0] b);
    wr(8'h81, b);
    exp_b.push_back(b);
  endtask

  // link agent: accept one request, optionally answer it
  task automatic serve(input int rdy_dly, input bit give, input int rsp_dly,
                       input logic [2:0] code, input logic [4:0] cnt, input logic [127:0] dat);
    int n = 0;
    @(negedge clk);
    while (!lreq_valid && n < 100) begin @(negedge clk); n++; end
    check("R4 request offered", {31'd0, lreq_valid}, 1);
    repeat (rdy_dly) @(negedge clk);
    lreq_ready = 1;
    @(negedge clk);
    lreq_ready = 0;
    req_hs++;
    if (give) begin
      repeat (rsp_dly) @(negedge clk);
      rsp_valid = 1; rsp_code = code; rsp_count = cnt; rsp_data = dat;
      @(negedge clk);
      rsp_valid = 0;
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] d;
    int hs0, vc0, n;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    rd_chk("R1 0x7D", 8'h7D, 0); rd_chk("R1 0x7E", 8'h7E, 0);
    rd_chk("R1 0x7F", 8'h7F, 0); rd_chk("R1 0x80", 8'h80, 0);
    rd_chk("R1 0x83", 8'h83, 0); rd_chk("R1 0x84", 8'h84, 0);
    rd_chk("R1 0x82", 8'h82, 0);

    // native write, 3 bytes, late ready (R2 R3 R4 R5 R6)
    prog(4'h8, 20'h5A3C1, 8'h02);
    rd_chk("R2 readback 0x7F", 8'h7F, 8'h85);
    push(8'hA1); push(8'hB2); push(8'hC3);
    wr(8'h83, 8'h01);
    rd_chk("R4 send bit set", 8'h83, 1);
    serve(4, 1, 2, 3'd3, 5'd3, '0);
    rd_chk("R4 send bit cleared", 8'h83, 0);
    rd_chk("R6 ack status", 8'h84, 8'h63);

    // I2C read with continuation flag, 4 bytes (R7)
    prog(4'h5, 20'h00050, 8'h03);
    wr(8'h83, 8'h01);
    serve(0, 1, 5, 3'd3, 5'd4, 128'h44332211);
    rd_chk("R6 read status", 8'h84, 8'h64);
    rd_chk("R7 byte0", 8'h82, 8'h11); rd_chk("R7 byte1", 8'h82, 8'h22);
    rd_chk("R7 byte2", 8'h82, 8'h33); rd_chk("R7 byte3", 8'h82, 8'h44);
    rd_chk("R7 empty", 8'h82, 8'h00); rd_chk("R7 still empty", 8'h82, 8'h00);

    // native NACK (R6)
    prog(4'h9, 20'hFFFFF, 8'h00);
    wr(8'h83, 8'h01);
    serve(0, 1, 0, 3'd1, 5'd0, '0);
    rd_chk("R6 nack status", 8'h84, 8'h20);

    // defers then ack (R8)
    prog(4'h9, 20'h00102, 8'h00);
    wr(8'h83, 8'h01);
    hs0 = req_hs;
    for (int k = 0; k < 3; k++) serve(1, 1, 1, 3'd2, 5'd0, '0);
    serve(0, 1, 0, 3'd3, 5'd1, 128'hAB);
    check("R8 reissue count", req_hs - hs0, 4);
    rd_chk("R8 final ack", 8'h84, 8'h61);
    rd_chk("R8 data", 8'h82, 8'hAB);

    // defer exhaustion (R8)
    prog(4'h1, 20'h00050, 8'h00);
    wr(8'h83, 8'h01);
    for (int k = 0; k < 4; k++) serve(0, 1, 0, 3'd6, 5'd0, '0);
    rd_chk("R8 exhausted busy", 8'h83, 0);
    rd_chk("R8 exhausted status", 8'h84, 8'hE0);

    // timeout (R9)
    prog(4'h8, 20'h00001, 8'h00);
    push(8'h5E);
    wr(8'h83, 8'h01);
    serve(0, 0, 0, 3'd0, 5'd0, '0);
    repeat (10) @(negedge clk);
    rd_chk("R9 still waiting", 8'h83, 1);
    n = 0;
    do begin rd(8'h83, d); n++; end while (d[0] && n < 200);
    rd_chk("R9 timeout status", 8'h84, 8'hE0);

    // invalid code (R10)
    prog(4'hA, 20'h00010, 8'h00);
    vc0 = valid_cycles;
    wr(8'h83, 8'h01);
    rd_chk("R10 no busy", 8'h83, 0);
    rd_chk("R10 bad status", 8'h84, 8'h80);
    repeat (3) @(negedge clk);
    check("R10 no request", valid_cycles - vc0, 0);

    // writes ignored while busy (R11)
    prog(4'h9, 20'h00077, 8'h00);
    wr(8'h83, 8'h01);
    hs0 = req_hs;
    wr(8'h7D, 8'hEE); wr(8'h81, 8'h99); wr(8'h76, 8'hFF); wr(8'h83, 8'h01);
    serve(0, 1, 0, 3'd3, 5'd1, 128'h3C);
    repeat (4) @(negedge clk);
    rd_chk("R11 addr kept", 8'h7D, 8'h77);
    rd_chk("R11 no second launch", 8'h83, 0);
    check("R11 one handshake", req_hs - hs0, 1);

    // R12 channel reset: non-FF value ignored, FF clears
    wr(8'h76, 8'h12);
    rd_chk("R12 status kept", 8'h84, 8'h61);
    wr(8'h76, 8'hFF);
    rd_chk("R12 status cleared", 8'h84, 8'h00);
    rd_chk("R12 rx cleared", 8'h82, 8'h00);

    // no-payload flag and payload overflow (R2 R3)
    prog(4'h0, 20'hABCDE, 8'h80);
    wr(8'h83, 8'h01);
    @(negedge clk);
    check("R2 no payload length", {27'd0, lreq_len}, 0);
    serve(0, 1, 0, 3'd3, 5'd0, '0);
    prog(4'h8, 20'h12345, 8'h0F);
    for (int k = 0; k < 17; k++) begin
      if (k < 16) push(8'(k * 7 + 1));
      else wr(8'h81, 8'hFE);
    end
    wr(8'h83, 8'h01);
    @(negedge clk);
    check("R3 16th byte kept", {24'd0, lreq_data[127:120]}, {24'd0, 8'(15 * 7 + 1)});
    serve(0, 1, 0, 3'd3, 5'd16, '0);
    rd_chk("R6 16 byte status", 8'h84, 8'h70);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule